// File: doc/BRIEF.md
# Address Map Decoder with Access Stretch

This block sits between a 16-bit CPU address bus and the chip's memories and external bus interface. For every address it picks exactly one target region: the relocatable 512-byte register block, on-chip RAM, on-chip EEPROM, a 32 KB flash, a 512-byte window that follows the register block, the external bus, or nothing at all. For the chosen target it also reports whether the access runs over an 8-bit bus and how many extra E-clock cycles it must be stretched.

An 8-bit mapping control register sets where the flash sits and whether it is enabled, the two stretch counts, and the narrow-bus option for the window that follows the registers. The access port is a valid/ready handshake. The CPU raises `acc_valid` with `acc_addr` and must hold both steady until it sees `acc_ready` high at a rising clock edge; that edge completes the access. The block stalls by holding `acc_ready` low, counting one stretch cycle per `eclk_en` pulse. Accesses that need no stretch are ready in the same cycle.

Top module: `memmap_decoder`

## Requirements
- R1: With the flash enable bit (bit 0) set, addresses whose top bit equals the flash placement bit (bit 1) select flash (`region_sel` bit 3) unless a higher-priority region claims them.
- R2: With the flash enable bit clear, no address selects flash, whatever the placement bit holds.
- R3: Region priority is fixed: register block (`region_sel` bit 0, 512 bytes at `reg_base`×2048), then RAM (bit 1, 0x0800–0x0BFF), then EEPROM (bit 2, 0x0D00–0x0FFF), then flash.
- R4: After reset the control register reads 0x02 in single-chip mode (`mode`=0) and 0x00 in every other mode.
- R5: In normal modes (`mode_special`=0) only the first write after reset changes the control register; in special modes every write takes effect.
- R6: In expanded modes (`mode`=1 narrow, `mode`=2 wide) the 512 bytes directly after the register block select the following window (`region_sel` bit 4), and the window moves with `reg_base`.
- R7: `stretch_cnt` equals bits 5:4 for the following window, bits 3:2 for external space, and 0 for every internal region and for unmapped addresses.
- R8: `bus_narrow` is 1 for external and window accesses in expanded-narrow mode, and for window accesses in expanded-wide mode when bit 6 is set; otherwise 0.
- R9: Exactly one `region_sel` bit is high; an unclaimed address selects external space (bit 5) in expanded modes and unmapped (bit 6) in single-chip and peripheral (`mode`=3) modes.
- R10: With `eclk_en` high, `acc_ready` stays low for exactly `stretch_cnt` cycles from the cycle `acc_valid` rises; cycles without an `eclk_en` pulse extend the stall one for one.
- R11: Bit 7 of the control register always reads 0; writes to it are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode: 0 single-chip, 1 expanded narrow, 2 expanded wide, 3 peripheral |
| mode_special | input | 1 | 1 for a special (test) mode, 0 for normal |
| reg_base | input | 5 | Register block base, address bits 15:11 |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| eclk_en | input | 1 | One-cycle E-clock pulse that paces stretching |
| acc_valid | input | 1 | Access request |
| acc_addr | input | 16 | Access address |
| acc_ready | output | 1 | Access may complete at this edge |
| region_sel | output | 7 | One-hot target region |
| bus_narrow | output | 1 | Access runs over an 8-bit bus |
| stretch_cnt | output | 2 | Extra E-clock cycles for this access |

## Verification
The stall assertions assume the CPU keeps `acc_valid` and `acc_addr` steady while `acc_ready` is low, and that `mode` and `reg_base` change only while reset is held; the bench changes the mode only inside a reset and keeps each access constant until its handshake. Decode properties are checked on every cycle regardless of `acc_valid`, so the random address sweeps run with the handshake idle and exercise overlapping regions by drawing addresses near the relocated register block and the fixed region edges.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE     = 2'd0,
    MODE_EXP_NARROW = 2'd1,
    MODE_EXP_WIDE   = 2'd2,
    MODE_PERIPH     = 2'd3
  } op_mode_e;

  // control register layout, msb first
  typedef struct packed {
    logic       zero;
    logic       rfw_narrow;
    logic [1:0] rfw_stretch;
    logic [1:0] ext_stretch;
    logic       flash_hi;
    logic       flash_en;
  } map_cfg_t;

  localparam int N_REGION = 7;
  localparam int RG_REG   = 0;
  localparam int RG_RAM   = 1;
  localparam int RG_EE    = 2;
  localparam int RG_FLASH = 3;
  localparam int RG_RFW   = 4;
  localparam int RG_EXT   = 5;
  localparam int RG_NONE  = 6;

  function automatic logic is_expanded(input op_mode_e m);
    return (m == MODE_EXP_NARROW) || (m == MODE_EXP_WIDE);
  endfunction
endpackage

// File: rtl/memmap_ctrl_reg.sv
module memmap_ctrl_reg
  import memmap_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  op_mode_e mode,
  input  logic     mode_special,
  input  logic     cfg_wr,
  input  logic [7:0] cfg_wdata,
  output map_cfg_t cfg
);
  logic locked;
  logic take;

  assign take = cfg_wr && (mode_special || !locked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg          <= '0;
      cfg.flash_hi <= (mode == MODE_SINGLE);
      locked       <= 1'b0;
    end else if (take) begin
      cfg    <= map_cfg_t'({1'b0, cfg_wdata[6:0]});
      locked <= locked | !mode_special;
    end
  end

  // R5: a locked register in normal mode ignores writes
  assert_write_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !mode_special && cfg_wr) |=> (cfg == $past(cfg)));

  // R11: bit 7 never reads back as 1 after a write
  assert_msb_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !cfg.zero);
endmodule

// File: rtl/memmap_region_dec.sv
module memmap_region_dec
  import memmap_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int ALIGN_LOG2 = 11,
  parameter int REG_BYTES  = 512,
  parameter int RAM_BASE   = 16'h0800,
  parameter int RAM_BYTES  = 1024,
  parameter int EE_BASE    = 16'h0D00,
  parameter int EE_BYTES   = 768,
  localparam int BASE_W    = ADDR_W - ALIGN_LOG2,
  localparam int WIDE_W    = ADDR_W + 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  op_mode_e          mode,
  input  logic [BASE_W-1:0] reg_base,
  input  map_cfg_t          cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic [N_REGION-1:0] sel
);
  localparam logic [WIDE_W-1:0] RAM_LO = WIDE_W'(RAM_BASE);
  localparam logic [WIDE_W-1:0] RAM_HI = WIDE_W'(RAM_BASE + RAM_BYTES);
  localparam logic [WIDE_W-1:0] EE_LO  = WIDE_W'(EE_BASE);
  localparam logic [WIDE_W-1:0] EE_HI  = WIDE_W'(EE_BASE + EE_BYTES);
  localparam logic [WIDE_W-1:0] WIN    = WIDE_W'(REG_BYTES);

  logic [WIDE_W-1:0] a, reg_lo, rfw_lo, rfw_hi;
  logic in_reg, in_ram, in_ee, in_flash, in_rfw;

  always_comb begin
    a      = {1'b0, addr};
    reg_lo = {1'b0, reg_base, {ALIGN_LOG2{1'b0}}};
    rfw_lo = reg_lo + WIN;
    rfw_hi = rfw_lo + WIN;
    in_reg   = (a >= reg_lo) && (a < rfw_lo);
    in_ram   = (a >= RAM_LO) && (a < RAM_HI);
    in_ee    = (a >= EE_LO)  && (a < EE_HI);
    in_flash = cfg.flash_en && (addr[ADDR_W-1] == cfg.flash_hi);
    in_rfw   = is_expanded(mode) && (a >= rfw_lo) && (a < rfw_hi);
  end

  always_comb begin
    sel = '0;
    if (in_reg)                sel[RG_REG]   = 1'b1;
    else if (in_ram)           sel[RG_RAM]   = 1'b1;
    else if (in_ee)            sel[RG_EE]    = 1'b1;
    else if (in_flash)         sel[RG_FLASH] = 1'b1;
    else if (in_rfw)           sel[RG_RFW]   = 1'b1;
    else if (is_expanded(mode)) sel[RG_EXT]  = 1'b1;
    else                       sel[RG_NONE]  = 1'b1;
  end

  // R9: one region at a time
  assert_onehot_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) == 1);

  // R2: a disabled flash is never selected
  assert_flash_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.flash_en |-> !sel[RG_FLASH]);

  // R9: no external space outside expanded modes
  assert_no_ext_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_expanded(mode) |-> !(sel[RG_EXT] || sel[RG_RFW]));
endmodule

// File: rtl/memmap_stretch.sv
module memmap_stretch #(
  parameter int CNT_W = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [CNT_W-1:0] stretch,
  input  logic             eclk_en,
  output logic             acc_ready
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e              state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE:
          if (acc_valid && stretch != '0) begin
            state <= ST_WAIT;
            cnt   <= stretch - {{(CNT_W-1){1'b0}}, eclk_en};
          end
        ST_WAIT:
          if (cnt == '0) begin
            if (acc_valid) state <= ST_IDLE;
          end else if (eclk_en) begin
            cnt <= cnt - 1'b1;
          end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    acc_ready = (state == ST_IDLE) ? (stretch == '0) : (cnt == '0);
  end

  // R10: without an E-clock pulse a pending stall does not end
  assert_hold_no_eclk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && cnt != '0 && !eclk_en) |=> !acc_ready);

  // R10: a new stretched access never reports ready in its first cycle
  assert_stall_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && acc_valid && stretch != '0) |-> !acc_ready);
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int ALIGN_LOG2 = 11,
  parameter int REG_BYTES  = 512,
  parameter int RAM_BASE   = 16'h0800,
  parameter int RAM_BYTES  = 1024,
  parameter int EE_BASE    = 16'h0D00,
  parameter int EE_BYTES   = 768,
  localparam int BASE_W    = ADDR_W - ALIGN_LOG2
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode,
  input  logic                mode_special,
  input  logic [BASE_W-1:0]   reg_base,
  input  logic                cfg_wr,
  input  logic [7:0]          cfg_wdata,
  output logic [7:0]          cfg_rdata,
  input  logic                eclk_en,
  input  logic                acc_valid,
  input  logic [ADDR_W-1:0]   acc_addr,
  output logic                acc_ready,
  output logic [N_REGION-1:0] region_sel,
  output logic                bus_narrow,
  output logic [1:0]          stretch_cnt
);
  op_mode_e m;
  map_cfg_t cfg;

  assign m = op_mode_e'(mode);

  memmap_ctrl_reg u_ctrl (
    .clk, .rst_n, .mode(m), .mode_special, .cfg_wr, .cfg_wdata, .cfg
  );

  memmap_region_dec #(
    .ADDR_W(ADDR_W), .ALIGN_LOG2(ALIGN_LOG2), .REG_BYTES(REG_BYTES),
    .RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES),
    .EE_BASE(EE_BASE), .EE_BYTES(EE_BYTES)
  ) u_dec (
    .clk, .rst_n, .mode(m), .reg_base, .cfg, .addr(acc_addr), .sel(region_sel)
  );

  always_comb begin
    stretch_cnt = 2'd0;
    if (region_sel[RG_RFW])      stretch_cnt = cfg.rfw_stretch;
    else if (region_sel[RG_EXT]) stretch_cnt = cfg.ext_stretch;
    bus_narrow = 1'b0;
    if (m == MODE_EXP_NARROW)
      bus_narrow = region_sel[RG_RFW] || region_sel[RG_EXT];
    else if (m == MODE_EXP_WIDE)
      bus_narrow = region_sel[RG_RFW] && cfg.rfw_narrow;
  end

  assign cfg_rdata = cfg;

  memmap_stretch #(.CNT_W(2)) u_stretch (
    .clk, .rst_n, .acc_valid, .stretch(stretch_cnt), .eclk_en, .acc_ready
  );

  // R7: internal targets are never stretched
  assert_internal_nostretch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (region_sel[RG_REG] || region_sel[RG_RAM] || region_sel[RG_EE] ||
     region_sel[RG_FLASH] || region_sel[RG_NONE]) |-> (stretch_cnt == 2'd0));

  // R8: the narrow flag only accompanies off-chip style targets
  assert_narrow_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_narrow |-> (region_sel[RG_RFW] || region_sel[RG_EXT]));
endmodule

// File: tb/memmap_decoder_bench.sv
module memmap_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        mode_special = 1'b0;
  logic [4:0]  reg_base = 5'd0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = 8'd0;
  logic [7:0]  cfg_rdata;
  logic        eclk_en = 1'b1;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_addr = 16'd0;
  logic        acc_ready;
  logic [6:0]  region_sel;
  logic        bus_narrow;
  logic [1:0]  stretch_cnt;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memmap_decoder u_memmap_decoder (
    .clk, .rst_n, .mode, .mode_special, .reg_base, .cfg_wr, .cfg_wdata,
    .cfg_rdata, .eclk_en, .acc_valid, .acc_addr, .acc_ready, .region_sel,
    .bus_narrow, .stretch_cnt
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      summary();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic expd(input logic [1:0] md);
    return md == 2'd1 || md == 2'd2;
  endfunction

  // expected region index from the requirement text
  function automatic int exp_region(input logic [15:0] a, input logic [7:0] c,
                                    input logic [1:0] md, input logic [4:0] base);
    int s, x;
    s = int'(base) * 2048;
    x = int'(a);
    if (x >= s && x < s + 512)                 return 0;
    if (x >= 16'h0800 && x < 16'h0C00)         return 1;
    if (x >= 16'h0D00 && x < 16'h1000)         return 2;
    if (c[0] && a[15] == c[1])                 return 3;
    if (expd(md) && x >= s + 512 && x < s + 1024) return 4;
    if (expd(md))                              return 5;
    return 6;
  endfunction

  function automatic int exp_stretch(input int r, input logic [7:0] c);
    if (r == 4) return int'(c[5:4]);
    if (r == 5) return int'(c[3:2]);
    return 0;
  endfunction

  function automatic int exp_narrow(input int r, input logic [7:0] c, input logic [1:0] md);
    if (md == 2'd1) return (r == 4 || r == 5) ? 1 : 0;
    if (md == 2'd2) return (r == 4 && c[6]) ? 1 : 0;
    return 0;
  endfunction

  task automatic do_reset(input logic [1:0] md, input logic sp);
    @(negedge clk);
    rst_n = 1'b0; mode = md; mode_special = sp;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
  endtask

  task automatic check_addr(input logic [15:0] a);
    int r;
    @(negedge clk);
    acc_addr = a;
    #1;
    r = exp_region(a, cfg_rdata, mode, reg_base);
    if (r == 3 || (!cfg_rdata[0] && a[15] == cfg_rdata[1] && r > 3))
      check(cfg_rdata[0] ? "R1" : "R2", int'(region_sel), 1 << r);
    else if (r < 3) check("R3", int'(region_sel), 1 << r);
    else if (r == 4) check("R6", int'(region_sel), 1 << r);
    else check("R9", int'(region_sel), 1 << r);
    check("R7", int'(stretch_cnt), exp_stretch(r, cfg_rdata));
    check("R8", int'(bus_narrow), exp_narrow(r, cfg_rdata, mode));
  endtask

  function automatic logic [15:0] pick_addr(input logic [4:0] base);
    int k;
    k = int'($urandom % 3);
    if (k == 0) return 16'($urandom);
    if (k == 1) return 16'(int'(base) * 2048 + int'($urandom % 1100) - 30);
    case ($urandom % 11)
      0: return 16'h7FFF;  1: return 16'h8000;  2: return 16'h0000;
      3: return 16'hFFFF;  4: return 16'h07FF;  5: return 16'h0BFF;
      6: return 16'h0C00;  7: return 16'h0CFF;  8: return 16'h0D00;
      9: return 16'h0FFF;  default: return 16'h1000;
    endcase
  endfunction

  // stall length in sampled cycles for one access; eclk held low for the first hold_k cycles
  task automatic stall_run(input logic [15:0] a, input int hold_k, input int exp_n, input string req);
    int low;
    low = 0;
    @(negedge clk);
    acc_addr = a; acc_valid = 1'b1; eclk_en = (hold_k == 0);
    #1;
    while (!acc_ready && low < 40) begin
      low++;
      @(negedge clk);
      eclk_en = (low >= hold_k);
      #1;
    end
    check(req, low, exp_n);
    @(negedge clk);
    acc_valid = 1'b0; eclk_en = 1'b1;
  endtask

  initial begin
    logic [7:0] w1, w2;
    void'($urandom(32'd20240517));

    for (int it = 0; it < 12; it++) begin
      logic [1:0] md;
      logic sp;
      md = 2'(it % 4);
      sp = (it / 4) % 2 == 1;
      reg_base = 5'($urandom);
      do_reset(md, sp);
      // R4: reset value depends on mode
      check("R4", int'(cfg_rdata), (md == 2'd0) ? 8'h02 : 8'h00);
      w1 = 8'($urandom) | 8'h80;
      wr(w1);
      check("R11", int'(cfg_rdata), int'(w1 & 8'h7F));
      w2 = ~w1;
      wr(w2);
      // R5: second write only lands in special modes
      check("R5", int'(cfg_rdata), int'(sp ? (w2 & 8'h7F) : (w1 & 8'h7F)));
      for (int j = 0; j < 250; j++) check_addr(pick_addr(reg_base));
      reg_base = 5'($urandom);
      for (int j = 0; j < 50; j++) check_addr(pick_addr(reg_base));
    end

    // directed: flash disabled, placement bit set (R2), then both placements (R1)
    reg_base = 5'd0;
    do_reset(2'd0, 1'b1);
    wr(8'h02);
    check_addr(16'h9000);
    check_addr(16'h2000);
    wr(8'h01);
    check_addr(16'h2000);
    check("R1", int'(region_sel), 1 << 3);
    check_addr(16'h9000);
    check("R9", int'(region_sel), 1 << 6);

    // window relocation and narrow option in expanded wide mode (R6, R8)
    do_reset(2'd2, 1'b1);
    reg_base = 5'd4;
    wr(8'h6C);   // narrow=1, window stretch 2, external stretch 3, flash off
    check_addr(16'h2200);
    check("R6", int'(region_sel), 1 << 4);
    check("R8", int'(bus_narrow), 1);
    check_addr(16'h21FF);
    check("R3", int'(region_sel), 1 << 0);
    check_addr(16'h2400);
    check("R9", int'(region_sel), 1 << 5);

    // stall lengths for each external stretch value (R10)
    for (int n = 0; n < 4; n++) begin
      wr(8'(n << 2));
      stall_run(16'h4000, 0, n, "R10");
    end
    wr(8'h20);   // window stretch 2
    stall_run(16'h2300, 0, 2, "R10");
    wr(8'h0C);   // external stretch 3, eclk withheld for 3 cycles
    stall_run(16'h5000, 3, 6, "R10");
    wr(8'h00);
    stall_run(16'h0900, 0, 0, "R10");

    summary();
  end
endmodule